// File: doc/BRIEF.md
# Scratchpad Store Buffer and Transfer Path Arbiter

This block sits between a compute engine and its scratchpad memory. The compute side pushes result words into a four-entry first-in, first-out buffer. A control-side drain request later pops the oldest word and writes it to a scratchpad address that the request supplies. If the compute side pushes faster than the control side drains, the block flags the failure and drops the word. Software is expected to drain the buffer in time.

The block also owns the only data path between the scratchpad and the register file. It grants that path to one transfer at a time. A transfer is either a buffer drain or a load of one scratchpad word into a register. A granted transfer holds the path for `XFER_CYCLES` cycles and touches the memory port only in its last cycle. For a load, the register write follows one cycle after the memory read, and a visibility pulse follows one cycle after the register write. Requests that arrive while the path is taken are refused and flagged. A drain on an empty buffer is refused and flagged. When a drain and a load arrive in the same idle cycle, the drain wins.

Top module: `spad_path_unit`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, and `full`, `busy`, `memWrEn`, `memRdEn`, `regWrEn`, `loadVisible`, `overflow`, `underflow` and `conflict` are all 0.
- R2: A push when fewer than DEPTH (default 4) words are held is stored, and `count` rises by one. `full` is 1 exactly when `count` equals DEPTH.
- R3: A push when DEPTH words are held drops the word. `overflow` is 1 in the cycle after the push, and the held contents are unchanged.
- R4: Drains write the buffered words to memory in the order in which they were pushed.
- R5: A drain request while idle and non-empty is granted. `busy` is 1 for exactly XFER_CYCLES cycles, starting the cycle after the request. In the last of those cycles, `memWrEn` is 1 with `memAddr` equal to the request address and `memWrData` equal to the oldest word. `count` falls by one in the cycle after that.
- R6: A drain request while idle and empty causes no grant and no memory write. `underflow` is 1 in the next cycle.
- R7: Any drain or load request while `busy` is 1 is ignored, and `conflict` is 1 in the next cycle.
- R8: A drain and a load requested in the same idle cycle with a non-empty buffer: the drain is granted, the load is ignored, and `conflict` is 1 in the next cycle.
- R9: A granted load raises `memRdEn` with `memAddr` equal to the load address in its last busy cycle. The memory returns data on the next edge. In the cycle after the read, `regWrEn` is 1, `regWrIdx` is the requested register and `regWrData` is the word read.
- R10: `loadVisible` is 1 in the cycle after `regWrEn`, and `visibleIdx` equals the register just written.
- R11: A push accepted while a drain is in flight is stored. When the pop and the push happen on the same edge, `count` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Compute-side store pushes a word |
| pushData | input | WIDTH | Word pushed |
| drainReq | input | 1 | Control-side request to pop one word to scratchpad |
| drainAddr | input | ADDR_W | Scratchpad address for the drained word |
| loadReq | input | 1 | Request to load a scratchpad word into a register |
| loadAddr | input | ADDR_W | Scratchpad address to load from |
| loadReg | input | REG_W | Target register index |
| memWrEn | output | 1 | Scratchpad write strobe |
| memRdEn | output | 1 | Scratchpad read strobe (data returns next edge) |
| memAddr | output | ADDR_W | Scratchpad address |
| memWrData | output | WIDTH | Scratchpad write data |
| memRdData | input | WIDTH | Scratchpad read data |
| regWrEn | output | 1 | Register file write strobe |
| regWrIdx | output | REG_W | Register written |
| regWrData | output | WIDTH | Data written to the register |
| loadVisible | output | 1 | Loaded register is now readable |
| visibleIdx | output | REG_W | Register that became readable |
| count | output | CNT_W | Words held in the buffer |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no word |
| busy | output | 1 | Transfer path is taken |
| overflow | output | 1 | Push was dropped on a full buffer (one-cycle pulse) |
| underflow | output | 1 | Drain was refused on an empty buffer (pulse) |
| conflict | output | 1 | Request refused because the path was taken (pulse) |

## Verification
The bench builds the block with DEPTH 4, a 16-bit word, a 6-bit scratchpad address, a 9-bit register index and XFER_CYCLES 3. With four entries, both the full and the overflow conditions arise after a handful of pushes. The 64-word address space allows a drained word to be loaded back and compared. Three-cycle transfers leave a middle busy cycle, in which a conflicting request and a concurrent push can both be placed.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;        // write pushData at tail
    logic pop;         // retire head entry
    logic grantDrain;  // latch drain address
    logic grantLoad;   // latch load address and register
    logic loadDone;    // memory read issued this cycle
  } xfer_strobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int XFER_CYCLES = 3,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int TMR_W      = $clog2(XFER_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pushValid,
  input  logic             drainReq,
  input  logic             loadReq,
  output xfer_strobe_t     strobe,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             busy,
  output logic             memWrEn,
  output logic             memRdEn,
  output logic             overflow,
  output logic             underflow,
  output logic             conflict
);
  logic [TMR_W-1:0] timer;
  logic             isDrain;
  logic             done;
  logic             idle;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign busy  = (timer != '0);
  assign idle  = !busy;
  assign done  = (timer == TMR_W'(1));

  always_comb begin
    strobe            = '0;
    strobe.push       = pushValid && !full;
    strobe.grantDrain = idle && drainReq && !empty;
    strobe.grantLoad  = idle && loadReq && !drainReq;
    strobe.pop        = done && isDrain;
    strobe.loadDone   = done && !isDrain;
  end

  assign memWrEn = strobe.pop;
  assign memRdEn = strobe.loadDone;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      timer     <= '0;
      isDrain   <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      conflict  <= 1'b0;
    end else begin
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (strobe.grantDrain || strobe.grantLoad) begin
        timer   <= TMR_W'(XFER_CYCLES);
        isDrain <= strobe.grantDrain;
      end else if (busy) begin
        timer <= timer - TMR_W'(1);
      end
      overflow  <= pushValid && full;
      underflow <= idle && drainReq && empty;
      conflict  <= (busy && (drainReq || loadReq)) || (idle && drainReq && loadReq);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pushValid && full && !memWrEn) |=> (overflow && full));
  assert_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && drainReq && !empty) |=> busy);
  assert_write_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> (busy && !memRdEn && !empty));
  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && drainReq && empty) |=> (underflow && !busy));
  assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (drainReq || loadReq)) |=> conflict);
endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 11,
  parameter int REG_W  = 9,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  xfer_strobe_t      strobe,
  input  logic [WIDTH-1:0]  pushData,
  input  logic [ADDR_W-1:0] drainAddr,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [REG_W-1:0]  loadReg,
  input  logic [WIDTH-1:0]  memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WIDTH-1:0]  memWrData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [WIDTH-1:0]  regWrData,
  output logic              loadVisible,
  output logic [REG_W-1:0]  visibleIdx
);
  logic [WIDTH-1:0]  entry [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [ADDR_W-1:0] xferAddr;
  logic [REG_W-1:0]  xferReg;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.push && (wrPtr == PTR_W'(e))) entry[e] <= pushData;
    end
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr       <= '0;
      rdPtr       <= '0;
      xferAddr    <= '0;
      xferReg     <= '0;
      regWrEn     <= 1'b0;
      regWrIdx    <= '0;
      loadVisible <= 1'b0;
      visibleIdx  <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      if (strobe.grantDrain)     xferAddr <= drainAddr;
      else if (strobe.grantLoad) xferAddr <= loadAddr;
      if (strobe.grantLoad) xferReg <= loadReg;
      regWrEn     <= strobe.loadDone;
      if (strobe.loadDone) regWrIdx <= xferReg;
      loadVisible <= regWrEn;
      if (regWrEn) visibleIdx <= regWrIdx;
    end
  end

  assign memAddr   = xferAddr;
  assign memWrData = entry[rdPtr];
  assign regWrData = memRdData;

  assert_regwr_follows_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadDone |=> (regWrEn && regWrIdx == $past(xferReg)));
  assert_visible_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    regWrEn |=> (loadVisible && visibleIdx == $past(regWrIdx)));
endmodule

// File: rtl/spad_path_unit.sv
module spad_path_unit
  import xfer_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int WIDTH       = 16,
  parameter int ADDR_W      = 11,
  parameter int REG_W       = 9,
  parameter int XFER_CYCLES = 3,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pushValid,
  input  logic [WIDTH-1:0]  pushData,
  input  logic              drainReq,
  input  logic [ADDR_W-1:0] drainAddr,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [REG_W-1:0]  loadReg,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WIDTH-1:0]  memWrData,
  input  logic [WIDTH-1:0]  memRdData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrIdx,
  output logic [WIDTH-1:0]  regWrData,
  output logic              loadVisible,
  output logic [REG_W-1:0]  visibleIdx,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              busy,
  output logic              overflow,
  output logic              underflow,
  output logic              conflict
);
  xfer_strobe_t strobe;

  xfer_ctrl #(.DEPTH(DEPTH), .XFER_CYCLES(XFER_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pushValid(pushValid), .drainReq(drainReq),
    .loadReq(loadReq), .strobe(strobe), .count(count), .full(full),
    .empty(empty), .busy(busy), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .overflow(overflow), .underflow(underflow), .conflict(conflict)
  );

  xfer_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .pushData(pushData),
    .drainAddr(drainAddr), .loadAddr(loadAddr), .loadReg(loadReg),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData),
    .loadVisible(loadVisible), .visibleIdx(visibleIdx)
  );
endmodule

// File: tb/spad_path_unit_test.sv
module spad_path_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, WIDTH = 16, ADDR_W = 6, REG_W = 9, NX = 3;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic pushValid = 0, drainReq = 0, loadReq = 0;
  logic [WIDTH-1:0] pushData = '0;
  logic [ADDR_W-1:0] drainAddr = '0, loadAddr = '0;
  logic [REG_W-1:0] loadReg = '0;
  logic memWrEn, memRdEn, regWrEn, loadVisible, full, empty, busy, overflow, underflow, conflict;
  logic [ADDR_W-1:0] memAddr;
  logic [WIDTH-1:0] memWrData, memRdData, regWrData;
  logic [REG_W-1:0] regWrIdx, visibleIdx;
  logic [CNT_W-1:0] count;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] shadow [2**ADDR_W];
  logic [WIDTH-1:0] ram [2**ADDR_W];

  spad_path_unit #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W), .REG_W(REG_W),
                   .XFER_CYCLES(NX)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WIDTH-1:0] initWord(int a);
    return WIDTH'(a * 5 + 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2**ADDR_W; i++) ram[i] <= initWord(i);
    end else begin
      if (memWrEn) ram[memAddr] <= memWrData;
      if (memRdEn) memRdData <= ram[memAddr];
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doPush(logic [WIDTH-1:0] d);
    bit wasFull = (q.size() == DEPTH);
    pushValid = 1; pushData = d;
    tick(); pushValid = 0;
    chk(overflow == wasFull, "R3", "overflow", overflow, wasFull);
    if (!wasFull) q.push_back(d);
    chk(count == q.size(), "R2", "count", count, q.size());
    chk(full == (q.size() == DEPTH), "R2", "full", full, q.size() == DEPTH);
  endtask

  task automatic doDrain(logic [ADDR_W-1:0] a);
    drainReq = 1; drainAddr = a;
    tick(); drainReq = 0;
    if (q.size() == 0) begin
      chk(underflow == 1 && busy == 0, "R6", "underflow/busy", {underflow, busy}, 2);
      tick();
      chk(memWrEn == 0 && count == 0, "R6", "no write", memWrEn, 0);
      return;
    end
    for (int k = 1; k <= NX; k++) begin
      chk(busy == 1, "R5", "busy", busy, 1);
      chk(memWrEn == (k == NX), "R5", "memWrEn timing", memWrEn, k == NX);
      if (k == NX) begin
        chk(memAddr == a, "R5", "memAddr", memAddr, a);
        chk(memWrData == q[0], "R4", "drain order", memWrData, q[0]);
      end else tick();
    end
    tick();
    shadow[a] = q.pop_front();
    chk(busy == 0 && count == q.size(), "R5", "count after drain", count, q.size());
  endtask

  task automatic doLoad(logic [ADDR_W-1:0] a, logic [REG_W-1:0] r);
    loadReq = 1; loadAddr = a; loadReg = r;
    tick(); loadReq = 0;
    for (int k = 1; k <= NX; k++) begin
      chk(busy == 1, "R9", "busy", busy, 1);
      chk(memRdEn == (k == NX), "R9", "memRdEn timing", memRdEn, k == NX);
      if (k == NX) chk(memAddr == a, "R9", "memAddr", memAddr, a);
      tick();
    end
    chk(regWrEn == 1 && regWrIdx == r, "R9", "regWr idx", regWrIdx, r);
    chk(regWrData == shadow[a], "R9", "regWr data", regWrData, shadow[a]);
    chk(loadVisible == 0, "R10", "visible early", loadVisible, 0);
    tick();
    chk(loadVisible == 1 && visibleIdx == r, "R10", "visible idx", visibleIdx, r);
    chk(regWrEn == 0, "R9", "regWr one cycle", regWrEn, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] a0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 2**ADDR_W; i++) shadow[i] = initWord(i);
    repeat (3) @(negedge clk);
    chk(count == 0 && empty && !full && !busy, "R1", "reset status", count, 0);
    chk(!memWrEn && !memRdEn && !regWrEn && !loadVisible, "R1", "reset strobes", 1, 0);
    chk(!overflow && !underflow && !conflict, "R1", "reset flags", 1, 0);
    rst_n = 1; tick();

    // fill, overflow, ordered drain, underflow
    for (int i = 0; i < DEPTH + 1; i++) doPush(WIDTH'(16'h100 + i));
    for (int i = 0; i < DEPTH; i++) doDrain(ADDR_W'(10 + i));
    doDrain(6'd3);
    doLoad(6'd11, 9'd287);
    doLoad(6'd40, 9'd5);

    // R8 drain beats load; R7 request during busy; R11 push during drain
    doPush(16'hA5A5);
    drainReq = 1; drainAddr = 6'd20; loadReq = 1; loadAddr = 6'd21; loadReg = 9'd7;
    tick(); drainReq = 0;
    chk(busy == 1 && conflict == 1, "R8", "drain wins, load flagged", conflict, 1);
    pushValid = 1; pushData = 16'h5A5A;
    tick(); pushValid = 0; loadReq = 0;
    chk(conflict == 1, "R7", "conflict while busy", conflict, 1);
    chk(count == 2, "R11", "push during drain", count, 2);
    tick();
    chk(memWrEn == 1 && memWrData == 16'hA5A5, "R8", "drain data", memWrData, 16'hA5A5);
    a0 = q.pop_front(); shadow[20] = a0; q.push_back(16'h5A5A);
    tick();
    chk(count == 1 && !busy && !regWrEn, "R8", "load dropped", regWrEn, 0);
    // R11 same-edge push and pop keeps count
    drainReq = 1; drainAddr = 6'd22; tick(); drainReq = 0;
    tick(); tick();
    chk(memWrEn == 1, "R11", "pop cycle", memWrEn, 1);
    pushValid = 1; pushData = 16'h0F0F; tick(); pushValid = 0;
    shadow[22] = q.pop_front(); q.push_back(16'h0F0F);
    chk(count == 1, "R11", "push+pop count", count, 1);
    doLoad(6'd22, 9'd100);

    // random mix
    for (int it = 0; it < 80; it++) begin
      int r = $urandom % 4;
      if (r < 2) doPush(WIDTH'($urandom));
      else if (r == 2) doDrain(ADDR_W'($urandom));
      else doLoad(ADDR_W'($urandom), REG_W'($urandom % 288));
    end
    while (q.size() > 0) doDrain(ADDR_W'($urandom));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule